// File: doc/BRIEF.md
# Multi-Width ALU with Flag Generation

This block is the combinational integer datapath of a 32-bit processor core. It adds, subtracts, ORs, ANDs or XORs two operands at one of three operand widths (byte, halfword, word) and returns the result cut to that width. Alongside the result it produces carry, overflow, sign and zero flags, each computed at the selected width rather than at the full datapath width.

The first operand is the destination, and for subtraction it is the minuend. The second operand is the source. The four flags are passed to a separate status register outside this block. Shifts, multiply, divide, decimal arithmetic and flag storage are handled elsewhere.

The block has no clock and no state. Its only modes are the operation code and the size code. There are therefore no states or transitions to name: every output is a pure function of the current inputs.

Top module: `multi_width_alu`

## Requirements
- R1: Size code 0 selects 8 bits, 1 selects 16 bits, 2 selects 32 bits, and code 3 is treated as 32 bits. Operand bits above the selected width have no effect on any output.
- R2: Result bits above the selected width are always zero.
- R3: Op code 0 adds. The result is the low width bits of dst+src, and carry is bit 8, 16 or 32 of the widened sum.
- R4: Op code 1 subtracts dst minus src. Carry is the bit just above the width in the widened difference, so it is set exactly when dst is below src unsigned (a borrow).
- R5: For an add, overflow is set when the sign bit of the result differs from the sign bits of both operands.
- R6: For a subtract, overflow is set when the operands' sign bits differ and the result's sign bit differs from the sign bit of dst.
- R7: Op codes 2, 3 and 4 return OR, AND and XOR of the sized operands, with carry and overflow forced to zero.
- R8: Sign equals the top bit of the sized result (bit 7, 15 or 31).
- R9: Zero is set exactly when the sized result is zero.
- R10: Op codes 5, 6 and 7 return a zero result with carry, overflow and sign clear. Zero is then set, in line with R9.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| dst_i | input | 32 | Destination operand; minuend for subtract |
| src_i | input | 32 | Source operand |
| op_i | input | 3 | Operation: 0 add, 1 sub, 2 or, 3 and, 4 xor |
| size_i | input | 2 | Width: 0 byte, 1 half, 2 or 3 word |
| result_o | output | 32 | Result, zero above the selected width |
| carry_o | output | 1 | Carry out or borrow |
| ovf_o | output | 1 | Signed overflow |
| sign_o | output | 1 | Top bit of the sized result |
| zero_o | output | 1 | Sized result equals zero |

## Verification
The bench builds the block with its default 32-bit datapath, so the byte and halfword widths come out as 8 and 16 bits. This places the carry boundaries at bits 8, 16 and 32 and the sign boundaries at bits 7, 15 and 31. Every operation code, including the undefined ones, is crossed with every size code. Operand pairs are drawn from each width's largest positive value, its most negative value, zero, one and all ones, and further pairs are random with junk in the upper bits. This exercises wrap, borrow and both overflow directions at every width.

// File: rtl/mwalu_pkg.sv
package mwalu_pkg;

    localparam int unsigned ALU_DATA_W = 32;
    localparam int unsigned ALU_OP_W   = 3;
    localparam int unsigned ALU_SZ_W   = 2;
    localparam int unsigned ALU_NUM_SZ = 3;

    typedef enum logic [ALU_OP_W-1:0] {
        OP_ADD = 3'd0,
        OP_SUB = 3'd1,
        OP_OR  = 3'd2,
        OP_AND = 3'd3,
        OP_XOR = 3'd4
    } alu_op_e;

    typedef enum logic [ALU_SZ_W-1:0] {
        SZ_BYTE = 2'd0,
        SZ_HALF = 2'd1,
        SZ_WORD = 2'd2
    } alu_size_e;

    // Width of lane g for a given datapath width: quarter, half, full.
    function automatic int unsigned lane_width(int unsigned g, int unsigned data_w);
        return (g == 0) ? data_w / 4 : (g == 1) ? data_w / 2 : data_w;
    endfunction

    // Maps a size code to a lane index; code 3 folds onto the word lane.
    function automatic logic [1:0] lane_of(logic [ALU_SZ_W-1:0] sz);
        return (sz == SZ_BYTE) ? 2'd0 : (sz == SZ_HALF) ? 2'd1 : 2'd2;
    endfunction

    function automatic logic is_logic_op(logic [ALU_OP_W-1:0] op);
        return (op == OP_OR) || (op == OP_AND) || (op == OP_XOR);
    endfunction

endpackage

// File: rtl/mwalu_addsub.sv
module mwalu_addsub #(
    parameter int unsigned DATA_W = 32,
    parameter int unsigned WIDTH  = 8
) (
    input  logic [DATA_W-1:0] dst_i,
    input  logic [DATA_W-1:0] src_i,
    input  logic              sub_i,
    output logic [DATA_W-1:0] res_o,
    output logic              carry_o,
    output logic              ovf_o
);
    localparam int unsigned MSB = WIDTH - 1;

    logic [WIDTH:0]   ext_a, ext_b, wide;
    logic [WIDTH-1:0] a_w, b_w, r_w;

    always_comb begin
        a_w   = dst_i[WIDTH-1:0];
        b_w   = src_i[WIDTH-1:0];
        ext_a = {1'b0, a_w};
        ext_b = {1'b0, b_w};
        wide  = sub_i ? (ext_a - ext_b) : (ext_a + ext_b);
        r_w   = wide[WIDTH-1:0];
        res_o = '0;
        res_o[WIDTH-1:0] = r_w;
        carry_o = wide[WIDTH];
        if (sub_i)
            ovf_o = (a_w[MSB] ^ b_w[MSB]) & (a_w[MSB] ^ r_w[MSB]);
        else
            ovf_o = (r_w[MSB] ^ a_w[MSB]) & (r_w[MSB] ^ b_w[MSB]);
    end

    always_comb begin
        if (!sub_i) begin
            // R3
            add_carry_chk: assert (carry_o == (r_w < a_w))
                else $error("add carry disagrees with unsigned wrap");
        end else begin
            // R4
            sub_borrow_chk: assert (carry_o == (a_w < b_w))
                else $error("subtract borrow disagrees with operand order");
        end
    end

endmodule

// File: rtl/mwalu_logic.sv
module mwalu_logic
    import mwalu_pkg::*;
#(
    parameter int unsigned DATA_W = 32
) (
    input  logic [DATA_W-1:0]   dst_i,
    input  logic [DATA_W-1:0]   src_i,
    input  logic [ALU_OP_W-1:0] op_i,
    input  logic [DATA_W-1:0]   mask_i,
    output logic [DATA_W-1:0]   res_o
);
    logic [DATA_W-1:0] raw;

    always_comb begin
        case (op_i)
            OP_OR:   raw = dst_i | src_i;
            OP_AND:  raw = dst_i & src_i;
            OP_XOR:  raw = dst_i ^ src_i;
            default: raw = '0;
        endcase
        res_o = raw & mask_i;
    end

endmodule

// File: rtl/mwalu_flags.sv
module mwalu_flags
    import mwalu_pkg::*;
#(
    parameter int unsigned DATA_W = 32
) (
    input  logic [DATA_W-1:0] res_i,
    input  logic [1:0]        lane_i,
    output logic              sign_o,
    output logic              zero_o
);
    localparam int unsigned TOP_B = lane_width(0, DATA_W) - 1;
    localparam int unsigned TOP_H = lane_width(1, DATA_W) - 1;
    localparam int unsigned TOP_W = DATA_W - 1;

    always_comb begin
        unique case (lane_i)
            2'd0:    sign_o = res_i[TOP_B];
            2'd1:    sign_o = res_i[TOP_H];
            default: sign_o = res_i[TOP_W];
        endcase
        zero_o = (res_i == '0);
    end

endmodule

// File: rtl/multi_width_alu.sv
module multi_width_alu
    import mwalu_pkg::*;
#(
    parameter int unsigned DATA_W = ALU_DATA_W
) (
    input  logic [DATA_W-1:0]   dst_i,
    input  logic [DATA_W-1:0]   src_i,
    input  logic [ALU_OP_W-1:0] op_i,
    input  logic [ALU_SZ_W-1:0] size_i,
    output logic [DATA_W-1:0]   result_o,
    output logic                carry_o,
    output logic                ovf_o,
    output logic                sign_o,
    output logic                zero_o
);
    localparam int unsigned BYTE_W = lane_width(0, DATA_W);
    localparam int unsigned HALF_W = lane_width(1, DATA_W);

    logic [DATA_W-1:0] as_res [ALU_NUM_SZ];
    logic              as_cy  [ALU_NUM_SZ];
    logic              as_ov  [ALU_NUM_SZ];
    logic [DATA_W-1:0] lane_mask [ALU_NUM_SZ];
    logic [DATA_W-1:0] logic_res;
    logic [1:0]        lane;
    logic              is_sub;

    assign lane   = lane_of(size_i);
    assign is_sub = (op_i == OP_SUB);

    for (genvar g = 0; g < ALU_NUM_SZ; g++) begin : g_lane
        localparam int unsigned LW = lane_width(g, DATA_W);
        if (LW == DATA_W) begin : g_full
            assign lane_mask[g] = '1;
        end else begin : g_part
            assign lane_mask[g] = {{(DATA_W-LW){1'b0}}, {LW{1'b1}}};
        end
        mwalu_addsub #(.DATA_W(DATA_W), .WIDTH(LW)) u_addsub (
            .dst_i   (dst_i),
            .src_i   (src_i),
            .sub_i   (is_sub),
            .res_o   (as_res[g]),
            .carry_o (as_cy[g]),
            .ovf_o   (as_ov[g])
        );
    end

    mwalu_logic #(.DATA_W(DATA_W)) u_logic (
        .dst_i  (dst_i),
        .src_i  (src_i),
        .op_i   (op_i),
        .mask_i (lane_mask[lane]),
        .res_o  (logic_res)
    );

    always_comb begin
        result_o = '0;
        carry_o  = 1'b0;
        ovf_o    = 1'b0;
        case (op_i)
            OP_ADD, OP_SUB: begin
                result_o = as_res[lane];
                carry_o  = as_cy[lane];
                ovf_o    = as_ov[lane];
            end
            OP_OR, OP_AND, OP_XOR: result_o = logic_res;
            default: ;
        endcase
    end

    mwalu_flags #(.DATA_W(DATA_W)) u_flags (
        .res_i  (result_o),
        .lane_i (lane),
        .sign_o (sign_o),
        .zero_o (zero_o)
    );

    always_comb begin
        if (lane == 2'd0) begin
            // R2
            upper_byte_chk: assert (result_o[DATA_W-1:BYTE_W] == '0)
                else $error("bits above byte result not clear");
        end
        if (lane == 2'd1) begin
            // R2
            upper_half_chk: assert (result_o[DATA_W-1:HALF_W] == '0)
                else $error("bits above half result not clear");
        end
        if (is_logic_op(op_i)) begin
            // R7
            logic_flags_chk: assert (!carry_o && !ovf_o)
                else $error("logical op left carry or overflow set");
        end
        if (op_i > OP_XOR) begin
            // R10
            undef_op_chk: assert (result_o == '0 && !carry_o && !ovf_o && !sign_o)
                else $error("undefined op produced nonzero output");
        end
        // R9
        zero_flag_chk: assert (zero_o == (result_o == '0))
            else $error("zero flag disagrees with result");
        if (op_i == OP_ADD && zero_o) begin
            // R5
            add_zero_ovf_chk: assert (!ovf_o || (dst_i[DATA_W-1] == 1'b1) || lane != 2'd2)
                else $error("positive word add overflowed to zero");
        end
    end

endmodule

// File: tb/multi_width_alu_bench.sv
module multi_width_alu_bench;

    localparam time CLK_PERIOD = 10;
    localparam int  MAX_CYCLES = 200000;

    logic clk = 1'b0;
    always #(CLK_PERIOD/2) clk = ~clk;

    logic [31:0] dst, src, result;
    logic [2:0]  op;
    logic [1:0]  size;
    logic        carry, ovf, sign, zero;

    multi_width_alu u_multi_width_alu (
        .dst_i    (dst),
        .src_i    (src),
        .op_i     (op),
        .size_i   (size),
        .result_o (result),
        .carry_o  (carry),
        .ovf_o    (ovf),
        .sign_o   (sign),
        .zero_o   (zero)
    );

    typedef struct {
        logic [31:0] r;
        logic        cy, ov, sf, zf;
        logic [2:0]  op;
        logic [1:0]  sz;
    } exp_t;

    exp_t sb[$];
    int   checks = 0;
    int   fails  = 0;
    int   cycles = 0;
    bit   finished = 0;

    function automatic int width_of(logic [1:0] s);
        return (s == 2'd0) ? 8 : (s == 2'd1) ? 16 : 32;
    endfunction

    function automatic exp_t model(logic [31:0] a32, logic [31:0] b32,
                                   logic [2:0] o, logic [1:0] s);
        exp_t e;
        int w;
        longint unsigned m, a, b, r, wide;
        w = width_of(s);
        m = (64'd1 << w) - 1;
        a = {32'd0, a32} & m;
        b = {32'd0, b32} & m;
        e.op = o; e.sz = s; e.cy = 0; e.ov = 0; r = 0;
        case (o)
            3'd0: begin
                wide = a + b; r = wide & m;
                e.cy = wide[w];
                e.ov = (((r ^ a) & (r ^ b)) >> (w - 1)) & 1;
            end
            3'd1: begin
                wide = a - b; r = wide & m;
                e.cy = wide[w];
                e.ov = (((a ^ b) & (a ^ r)) >> (w - 1)) & 1;
            end
            3'd2: r = a | b;
            3'd3: r = a & b;
            3'd4: r = a ^ b;
            default: r = 0;
        endcase
        e.r  = r[31:0];
        e.sf = r[w-1];
        e.zf = (r == 0);
        return e;
    endfunction

    task automatic check32(string tag, logic [31:0] act, logic [31:0] exp, exp_t e);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s op=%0d size=%0d actual=%h expected=%h", tag, e.op, e.sz, act, exp);
        end
    endtask

    task automatic check1(string tag, logic act, logic exp, exp_t e);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s op=%0d size=%0d actual=%b expected=%b", tag, e.op, e.sz, act, exp);
        end
    endtask

    task automatic drive(logic [31:0] a, logic [31:0] b, logic [2:0] o, logic [1:0] s);
        @(posedge clk);
        dst = a; src = b; op = o; size = s;
        sb.push_back(model(a, b, o, s));
    endtask

    // Monitor: compares half a period after each stimulus.
    always @(negedge clk) begin
        if (sb.size() > 0) begin
            exp_t e;
            int w;
            string rt, ct, ot;
            logic [31:0] upper;
            e = sb.pop_front();
            w = width_of(e.sz);
            case (e.op)
                3'd0:             begin rt = "R1/R3"; ct = "R3"; ot = "R5"; end
                3'd1:             begin rt = "R1/R4"; ct = "R4"; ot = "R6"; end
                3'd2, 3'd3, 3'd4: begin rt = "R1/R7"; ct = "R7"; ot = "R7"; end
                default:          begin rt = "R10";   ct = "R10"; ot = "R10"; end
            endcase
            check32(rt, result, e.r, e);
            upper = (w == 32) ? 32'd0 : (result >> w);
            check32("R2", upper, 32'd0, e);
            check1(ct, carry, e.cy, e);
            check1(ot, ovf, e.ov, e);
            check1("R8", sign, e.sf, e);
            check1("R9", zero, e.zf, e);
        end
    end

    always @(posedge clk) begin
        cycles++;
        if (cycles > MAX_CYCLES && !finished) begin
            finished = 1;
            checks++;
            fails++;
            $display("FAIL watchdog expired actual=%0d expected<=%0d", cycles, MAX_CYCLES);
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        dst = '0; src = '0; op = '0; size = '0;
        repeat (2) @(posedge clk);
        // Quiet starting point: 0 + 0 at byte width.
        drive(32'd0, 32'd0, 3'd0, 2'd0);
        for (int s = 0; s < 4; s++) begin
            int w;
            logic [31:0] edges [6];
            w = width_of(2'(s));
            edges[0] = 32'd0;
            edges[1] = 32'd1;
            edges[2] = 32'((64'd1 << (w - 1)) - 1);
            edges[3] = 32'(64'd1 << (w - 1));
            edges[4] = 32'hFFFF_FFFF;
            edges[5] = 32'hA5A5_0000 | edges[2];
            for (int o = 0; o < 8; o++) begin
                for (int i = 0; i < 6; i++)
                    for (int j = 0; j < 6; j++)
                        drive(edges[i], edges[j], 3'(o), 2'(s));
                for (int k = 0; k < 15; k++)
                    drive($urandom, $urandom, 3'(o), 2'(s));
            end
        end
        // R1: upper operand junk must not change a byte result.
        drive(32'hFFFF_FF01, 32'h1234_56FF, 3'd0, 2'd0);
        drive(32'h8000_0000, 32'h0000_0001, 3'd1, 2'd1);
        repeat (2) @(posedge clk);
        wait (sb.size() == 0);
        @(negedge clk);
        finished = 1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule